// File: doc/BRIEF.md
# Selectable Parallel Prefix Adder

A purely combinational adder for two unsigned operands of parameterised width. The result is the sum reduced modulo 2^WIDTH. There is no carry input, and the carry out of the top bit is dropped. Each bit position first forms a propagate term (the operands' bits differ) and a generate term (both bits are one). A carry network then turns these terms into the carry out of every bit. Each sum bit is the propagate term of its position XORed with the carry coming out of the position below it.

The parameter `TOPOLOGY` picks the carry network when the design is built.
- Value 1, the default, selects a dense prefix network. It has log2(WIDTH) levels. At each level every node combines with the node one stride below it, and the stride doubles from one level to the next.
- Value 2 selects a sparse network. An upward sweep combines only the nodes at the ends of aligned power-of-two groups. A downward sweep then fills in the positions that are still missing.
- Value 0 selects a ripple chain. The carry is passed from bit to bit as the majority of the two operand bits and the incoming carry.

All three networks give the same sum. They differ only in logic depth and node count.

Top module: `prefixAdder`

## Requirements
- R1: `sum` equals (a + b) mod 2^WIDTH for any pair of operands, with no clock and no carry input.
- R2: TOPOLOGY 0 (ripple), 1 (dense, default) and 2 (sparse) give identical sums. The internal carry term of every bit i equals the true carry out of bit i.
- R3: Sum bit 0 equals a[0] XOR b[0].
- R4: When either operand is zero, `sum` equals the other operand, and 0 + 0 gives 0.
- R5: Complementary operands (b equal to the bitwise inverse of a) give all ones.
- R6: All ones plus one, in either operand order, gives zero. The carry out of the top bit is discarded.
- R7: A carry that runs through k low bits is delivered correctly: (2^k − 1) + 1 = 2^k for every k below WIDTH.
- R8: A width that is not a power of two (13) adds correctly in all three topologies.
- R9: Alternating bit patterns add correctly: 0x5555 + 0x5555 = 0xAAAA, and 0xAAAA + 0xAAAA = 0x5554 at width 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| sum | output | WIDTH | Sum reduced modulo 2^WIDTH |

## Verification
A wrong node in a carry network shows as a wrong sum bit at the node's own position, or at a position above it. It shows only for operand pairs where that node's carry matters. Long carry runs, complementary operands and all-ones operands are therefore driven, so that every level of each network decides the result. The block has no state, so a fault appears in the same cycle as the operands that expose it. All three topologies are compared against the native sum, and against each other, at a power-of-two width and at an odd width.

// File: rtl/prefixAdderPkg.sv
package prefixAdderPkg;

  typedef enum int {
    TOPO_RIPPLE = 0,
    TOPO_DENSE  = 1,
    TOPO_SPARSE = 2
  } topo_e;

  // one-hot selection of the carry network, decoded from the parameter
  typedef struct packed {
    logic useRipple;
    logic useDense;
    logic useSparse;
  } netSel_t;

  function automatic netSel_t decodeTopo(input int topo);
    netSel_t sel;
    sel.useRipple = (topo == TOPO_RIPPLE);
    sel.useDense  = (topo == TOPO_DENSE);
    sel.useSparse = (topo == TOPO_SPARSE);
    return sel;
  endfunction

  function automatic int levelsFor(input int w);
    return (w <= 1) ? 0 : $clog2(w);
  endfunction

endpackage

// File: rtl/pgGen.sv
module pgGen #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p,
  output logic [W-1:0] g
);
  for (genvar i = 0; i < W; i++) begin : gBit
    assign p[i] = a[i] ^ b[i];
    assign g[i] = a[i] & b[i];
  end
endmodule

// File: rtl/rippleNet.sv
module rippleNet #(
  parameter int W = 16
) (
  input  logic [W-1:0] p,
  input  logic [W-1:0] g,
  output logic [W-1:0] gOut
);
  // majority(a, b, c) rewritten as g | (p & c); the carry into bit 0 is zero
  for (genvar i = 0; i < W; i++) begin : gBit
    logic co;
    if (i == 0) begin : gFirst
      assign co = g[i];
    end else begin : gNext
      assign co = g[i] | (p[i] & gBit[i-1].co);
    end
    assign gOut[i] = co;
  end
endmodule

// File: rtl/denseNet.sv
module denseNet #(
  parameter int W = 16
) (
  input  logic [W-1:0] p,
  input  logic [W-1:0] g,
  output logic [W-1:0] gOut
);
  import prefixAdderPkg::*;
  localparam int NS = levelsFor(W);

  if (NS == 0) begin : gNone
    assign gOut = g;
  end else begin : gTree
    logic [W-1:0] pL [0:NS-1];
    logic [W-1:0] gL [0:NS];
    assign pL[0] = p;
    assign gL[0] = g;
    for (genvar s = 0; s < NS; s++) begin : gLvl
      localparam int ST = 1 << s;
      for (genvar i = 0; i < W; i++) begin : gNode
        if (i >= ST) begin : gComb
          assign gL[s+1][i] = gL[s][i] | (pL[s][i] & gL[s][i-ST]);
          if (s < NS - 1) begin : gP
            assign pL[s+1][i] = pL[s][i] & pL[s][i-ST];
          end
        end else begin : gPass
          assign gL[s+1][i] = gL[s][i];
          if (s < NS - 1) begin : gP
            assign pL[s+1][i] = pL[s][i];
          end
        end
      end
    end
    assign gOut = gL[NS];
  end
endmodule

// File: rtl/sparseNet.sv
module sparseNet #(
  parameter int W = 16
) (
  input  logic [W-1:0] p,
  input  logic [W-1:0] g,
  output logic [W-1:0] gOut
);
  import prefixAdderPkg::*;
  localparam int FS = levelsFor(W);
  localparam int NS = 2 * FS;

  if (NS == 0) begin : gNone
    assign gOut = g;
  end else begin : gTree
    logic [W-1:0] pL [0:NS-1];
    logic [W-1:0] gL [0:NS];
    assign pL[0] = p;
    assign gL[0] = g;
    for (genvar k = 0; k < NS; k++) begin : gLvl
      // upward sweep: stride 1,2,4..; downward sweep: stride halves to 1
      localparam bit FWD   = (k < FS);
      localparam int ST    = FWD ? (1 << k) : (1 << (NS - 1 - k));
      localparam int FIRST = FWD ? (2 * ST - 1) : (3 * ST - 1);
      for (genvar i = 0; i < W; i++) begin : gNode
        if (i >= FIRST && ((i - FIRST) % (2 * ST)) == 0) begin : gComb
          assign gL[k+1][i] = gL[k][i] | (pL[k][i] & gL[k][i-ST]);
          if (k < NS - 1) begin : gP
            assign pL[k+1][i] = pL[k][i] & pL[k][i-ST];
          end
        end else begin : gPass
          assign gL[k+1][i] = gL[k][i];
          if (k < NS - 1) begin : gP
            assign pL[k+1][i] = pL[k][i];
          end
        end
      end
    end
    assign gOut = gL[NS];
  end
endmodule

// File: rtl/sumForm.sv
module sumForm #(
  parameter int W = 16
) (
  input  logic [W-1:0] p,
  input  logic [W-1:0] cInto,
  output logic [W-1:0] sum
);
  assign sum = p ^ cInto;
endmodule

// File: rtl/prefixAdder.sv
module prefixAdder #(
  parameter int WIDTH    = 16,
  parameter int TOPOLOGY = 1
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum
);
  import prefixAdderPkg::*;
  localparam netSel_t SEL = decodeTopo(TOPOLOGY);

  logic [WIDTH-1:0] p;
  logic [WIDTH-1:0] g;
  logic [WIDTH-1:0] gPre;
  logic [WIDTH-1:0] cInto;

  pgGen #(.W(WIDTH)) u_pg (.a(a), .b(b), .p(p), .g(g));

  if (SEL.useRipple) begin : gRipple
    rippleNet #(.W(WIDTH)) u_net (.p(p), .g(g), .gOut(gPre));
  end else if (SEL.useSparse) begin : gSparse
    sparseNet #(.W(WIDTH)) u_net (.p(p), .g(g), .gOut(gPre));
  end else begin : gDense
    denseNet #(.W(WIDTH)) u_net (.p(p), .g(g), .gOut(gPre));
  end

  if (WIDTH == 1) begin : gOne
    assign cInto = 1'b0;
  end else begin : gMany
    assign cInto = {gPre[WIDTH-2:0], 1'b0};
  end

  sumForm #(.W(WIDTH)) u_sum (.p(p), .cInto(cInto), .sum(sum));
endmodule

// File: rtl/prefixAdderChk.sv
module prefixAdderChk #(
  parameter int W = 16
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [W-1:0] sum,
  input logic [W-1:0] gPre
);
  logic [W:0] full;
  logic [W:0] carries;
  assign full    = {1'b0, a} + {1'b0, b};
  assign carries = full ^ {1'b0, a} ^ {1'b0, b};

  always_comb begin
    if (!$isunknown({a, b})) begin
      assert_sum_wraps_R1: assert (sum == full[W-1:0])
        else $error("sum %h != %h", sum, full[W-1:0]);
      assert_carry_terms_R2: assert (gPre == carries[W:1])
        else $error("carry terms %h != %h", gPre, carries[W:1]);
      assert_low_bit_R3: assert (sum[0] == (a[0] ^ b[0]))
        else $error("bit0 wrong");
      if (b == '0) begin
        assert_zero_operand_R4: assert (sum == a)
          else $error("a+0 wrong");
      end
      if (a == ~b) begin
        assert_complement_R5: assert (sum == '1)
          else $error("a+~a wrong");
      end
    end
  end
endmodule

bind prefixAdder prefixAdderChk #(.W(WIDTH)) u_chk (
  .a(a), .b(b), .sum(sum), .gPre(gPre)
);

// File: tb/test_prefixAdder.sv
`timescale 1ns/1ps
module test_prefixAdder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [15:0] a16 = '0, b16 = '0;
  logic [15:0] s16 [0:2];
  logic [12:0] s13 [0:2];

  // index = topology: 0 ripple, 1 dense, 2 sparse
  prefixAdder #(.WIDTH(16), .TOPOLOGY(1)) i_prefixAdder (.a(a16), .b(b16), .sum(s16[1]));
  prefixAdder #(.WIDTH(16), .TOPOLOGY(0)) i_rip16 (.a(a16), .b(b16), .sum(s16[0]));
  prefixAdder #(.WIDTH(16), .TOPOLOGY(2)) i_spa16 (.a(a16), .b(b16), .sum(s16[2]));
  prefixAdder #(.WIDTH(13), .TOPOLOGY(0)) i_rip13 (.a(a16[12:0]), .b(b16[12:0]), .sum(s13[0]));
  prefixAdder #(.WIDTH(13), .TOPOLOGY(1)) i_den13 (.a(a16[12:0]), .b(b16[12:0]), .sum(s13[1]));
  prefixAdder #(.WIDTH(13), .TOPOLOGY(2)) i_spa13 (.a(a16[12:0]), .b(b16[12:0]), .sum(s13[2]));

  typedef struct {
    logic [15:0] e16;
    logic [12:0] e13;
    logic        b0;
    string       tag;
  } item_t;
  item_t q[$];

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] x, input logic [15:0] y, input string tag);
    item_t it;
    logic [12:0] x13, y13;
    @(posedge clk);
    #1;
    a16 = x;
    b16 = y;
    x13 = x[12:0];
    y13 = y[12:0];
    it.e16 = x + y;
    it.e13 = x13 + y13;
    it.b0  = x[0] ^ y[0];
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compare half a cycle after each drive
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (!rst && q.size() > 0) begin
        it = q.pop_front();
        for (int t = 0; t < 3; t++) begin
          check({it.tag, " w16 topo", $sformatf("%0d", t)}, s16[t], it.e16);
          check({it.tag, " R8 w13 topo", $sformatf("%0d", t)}, {3'b0, s13[t]}, {3'b0, it.e13});
        end
        check({it.tag, " R2 ripple vs dense"}, s16[0], s16[1]);
        check({it.tag, " R2 sparse vs dense"}, s16[2], s16[1]);
        check({it.tag, " R3 bit0"}, {15'b0, s16[1][0]}, {15'b0, it.b0});
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired R1 actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    drive(16'h0000, 16'h0000, "R4 reset-state zero sum");
    drive(16'h1234, 16'h0000, "R4 b zero");
    drive(16'h0000, 16'hBEEF, "R4 a zero");
    drive(16'h5A3C, ~16'h5A3C, "R5 complement");
    drive(16'hFFFF, 16'h0000, "R5 all ones with zero");
    drive(16'hFFFF, 16'h0001, "R6 ones plus one");
    drive(16'h0001, 16'hFFFF, "R6 one plus ones");
    drive(16'hFFFF, 16'hFFFF, "R6 ones plus ones");
    drive(16'h5555, 16'h5555, "R9 alternating 5");
    drive(16'hAAAA, 16'hAAAA, "R9 alternating A");
    drive(16'hAAAA, 16'h5555, "R9 R5 alternating mixed");
    drive(16'h0001, 16'h0001, "R3 low bits both one");
    for (int k = 1; k < 16; k++) begin
      drive(16'((32'd1 << k) - 1), 16'h0001, "R7 carry run");
      drive(16'h0001, 16'((32'd1 << k) - 1), "R7 carry run swapped");
    end
    for (int n = 0; n < 400; n++) begin
      drive(16'($urandom), 16'($urandom), "R1 random");
    end
    @(posedge clk);
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule